// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block holds the per-pin interrupt logic of one GPIO bank built from several eight-pin ports. Every pin has its own trigger setting, chosen from five kinds: low level, high level, rising edge, falling edge and either edge. A pin that meets its trigger latches a status bit. Software clears status through a write-one-to-clear register. An enable bit per pin decides whether that status reaches the single bank interrupt line, which is the OR over every port of status AND enable.

Pin inputs arrive already synchronized from the port logic. The block keeps one sample of the previous input per pin and uses it to find edges. Software reaches the registers through a simple write strobe and a combinational read port. Status, enable and trigger configuration each also have a masked alias, so one pin can be changed without a read-modify-write.

Top module: `gpio_irq_bank`

## Requirements
- R1: Out of reset every status and enable bit is 0, every pin is set to rising-edge trigger (trigger word reads 0x0000FFFF), and `irq` is 0.
- R2: Address bits 7:4 select the group and bits 3:2 select the port. Bits 1:0 must be 0 for an access to take effect. The groups are 0x4 status, 0x5 enable, 0x6 trigger, 0x7 clear, 0xC masked status, 0xD masked enable and 0xE masked trigger. For pin k, the trigger word holds polarity at bit k, edge select at bit 8+k and any-edge at bit 16+k.
- R3: The trigger codes edge=1, any=0, polarity=1 (rising) and edge=1, any=0, polarity=0 (falling) set status on that transition only. The bit then stays set until software clears it.
- R4: The code edge=1, any=1 sets status on both rising and falling transitions.
- R5: The code edge=0 sets status in every cycle that the pin sits at its active level: high when polarity=1, low when polarity=0. The bit therefore reappears after a clear while that level persists.
- R6: Writing 1 to bit k of the clear group clears status bit k, and writing 0 leaves it unchanged. A write to the status group acts the same way.
- R7: When a detection and a clear hit the same pin in the same cycle, the status bit ends up set.
- R8: In a masked status or enable write, bits 15:8 select pins and bits 7:0 give their new values. In a masked trigger write, bits 31:24 select pins and the values sit at k, 8+k and 16+k. A masked alias reads back the same as its base group.
- R9: Status bits latch whatever the value of the pin's enable bit.
- R10: `irq` is 1 exactly when some pin in any port has status and enable both set. It follows a status change in the same cycle as that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPORTS*8 | Synchronized pin levels; pin k of port p is bit 8p+k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Combinational read data; 0 for the clear group and for unmapped addresses |
| irq | output | 1 | Bank interrupt request |

## Verification
A wrong previous-sample register shows up as a missed or doubled edge. It appears in the status read one cycle after the pin moves. A corrupted enable or trigger bit changes `irq`, or the trigger read-back, on the next read. A faulty clear path shows as status that fails to drop, or that drops while a level or edge is still asserting it. The scoreboard compares the read data and `irq` in the cycle after each stimulus, so every such fault surfaces within two cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_PINS = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    localparam logic [3:0] GRP_STA   = 4'h4;
    localparam logic [3:0] GRP_ENB   = 4'h5;
    localparam logic [3:0] GRP_TRG   = 4'h6;
    localparam logic [3:0] GRP_CLR   = 4'h7;
    localparam logic [3:0] GRP_STA_M = 4'hC;
    localparam logic [3:0] GRP_ENB_M = 4'hD;
    localparam logic [3:0] GRP_TRG_M = 4'hE;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STA_W1C,
        OP_STA_MSK,
        OP_ENB,
        OP_ENB_MSK,
        OP_TRG,
        OP_TRG_MSK
    } wr_op_e;

    function automatic wr_op_e group_to_op(input logic [3:0] grp);
        wr_op_e op;
        unique case (grp)
            GRP_STA, GRP_CLR: op = OP_STA_W1C;
            GRP_STA_M:        op = OP_STA_MSK;
            GRP_ENB:          op = OP_ENB;
            GRP_ENB_M:        op = OP_ENB_MSK;
            GRP_TRG:          op = OP_TRG;
            GRP_TRG_M:        op = OP_TRG_MSK;
            default:          op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] pin_i,
    input  logic [PINS-1:0] prev_i,
    input  logic [PINS-1:0] pol_i,
    input  logic [PINS-1:0] edg_i,
    input  logic [PINS-1:0] any_i,
    output logic [PINS-1:0] hit_o
);

    for (genvar k = 0; k < PINS; k++) begin : g_pin
        logic rise_k;
        logic fall_k;
        logic edge_hit_k;
        logic lvl_hit_k;

        assign rise_k     = pin_i[k] & ~prev_i[k];
        assign fall_k     = ~pin_i[k] & prev_i[k];
        assign edge_hit_k = any_i[k] ? (rise_k | fall_k)
                                     : (pol_i[k] ? rise_k : fall_k);
        assign lvl_hit_k  = pol_i[k] ? pin_i[k] : ~pin_i[k];
        assign hit_o[k]   = edg_i[k] ? edge_hit_k : lvl_hit_k;
    end

endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PORT_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_op_e            op_o [NPORTS]
);

    always_comb begin
        wr_op_e grp_op;
        logic   aligned;
        grp_op  = group_to_op(wr_addr[7:4]);
        aligned = (wr_addr[1:0] == 2'b00);
        for (int p = 0; p < NPORTS; p++) begin
            if (wr_en && aligned && (int'(wr_addr[2 +: PORT_W]) == p)) begin
                op_o[p] = grp_op;
            end else begin
                op_o[p] = OP_NONE;
            end
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_i,
    input  wr_op_e            op_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PINS-1:0]   sta_o,
    output logic [PINS-1:0]   enb_o,
    output logic [PINS-1:0]   pol_o,
    output logic [PINS-1:0]   edg_o,
    output logic [PINS-1:0]   any_o
);

    typedef struct packed {
        logic [PINS-1:0] sta;
        logic [PINS-1:0] enb;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] edg;
        logic [PINS-1:0] any;
        logic [PINS-1:0] prev;
    } port_state_t;

    localparam port_state_t RESET_STATE = '{
        sta:  '0,
        enb:  '0,
        pol:  '1,
        edg:  '1,
        any:  '0,
        prev: '0
    };

    port_state_t     st_d, st_q;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] val_lo;
    logic [PINS-1:0] sel_mid;
    logic [PINS-1:0] sel_top;

    assign val_lo  = wdata_i[0 +: PINS];
    assign sel_mid = wdata_i[PINS +: PINS];
    assign sel_top = wdata_i[3*PINS +: PINS];

    gpio_irq_detect #(.PINS(PINS)) u_detect (
        .pin_i  (pin_i),
        .prev_i (st_q.prev),
        .pol_i  (st_q.pol),
        .edg_i  (st_q.edg),
        .any_i  (st_q.any),
        .hit_o  (hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        unique case (op_i)
            OP_STA_W1C: st_d.sta = st_q.sta & ~val_lo;
            OP_STA_MSK: st_d.sta = (st_q.sta & ~sel_mid) | (val_lo & sel_mid);
            OP_ENB:     st_d.enb = val_lo;
            OP_ENB_MSK: st_d.enb = (st_q.enb & ~sel_mid) | (val_lo & sel_mid);
            OP_TRG: begin
                st_d.pol = wdata_i[0 +: PINS];
                st_d.edg = wdata_i[PINS +: PINS];
                st_d.any = wdata_i[2*PINS +: PINS];
            end
            OP_TRG_MSK: begin
                st_d.pol = (st_q.pol & ~sel_top) | (wdata_i[0 +: PINS] & sel_top);
                st_d.edg = (st_q.edg & ~sel_top) | (wdata_i[PINS +: PINS] & sel_top);
                st_d.any = (st_q.any & ~sel_top) | (wdata_i[2*PINS +: PINS] & sel_top);
            end
            default: ;
        endcase
        st_d.sta = st_d.sta | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign sta_o = st_q.sta;
    assign enb_o = st_q.enb;
    assign pol_o = st_q.pol;
    assign edg_o = st_q.edg;
    assign any_o = st_q.any;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORTS*PORT_PINS-1:0] pin_in,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        irq
);

    localparam int PINS   = PORT_PINS;
    localparam int NBITS  = NPORTS * PINS;
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    wr_op_e           op_arr [NPORTS];
    logic [NBITS-1:0] sta_all;
    logic [NBITS-1:0] enb_all;
    logic [NBITS-1:0] pol_all;
    logic [NBITS-1:0] edg_all;
    logic [NBITS-1:0] any_all;

    gpio_irq_decode #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op_o    (op_arr)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        gpio_irq_port #(.PINS(PINS)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_in[g*PINS +: PINS]),
            .op_i    (op_arr[g]),
            .wdata_i (wr_data),
            .sta_o   (sta_all[g*PINS +: PINS]),
            .enb_o   (enb_all[g*PINS +: PINS]),
            .pol_o   (pol_all[g*PINS +: PINS]),
            .edg_o   (edg_all[g*PINS +: PINS]),
            .any_o   (any_all[g*PINS +: PINS])
        );
    end

    assign irq = |(sta_all & enb_all);

    always_comb begin
        int unsigned rport;
        int unsigned rbase;
        rport   = int'(rd_addr[2 +: PORT_W]);
        rbase   = rport * PINS;
        rd_data = '0;
        if ((rd_addr[1:0] == 2'b00) && (rport < NPORTS)) begin
            unique case (rd_addr[7:4])
                GRP_STA, GRP_STA_M: rd_data[0 +: PINS] = sta_all[rbase +: PINS];
                GRP_ENB, GRP_ENB_M: rd_data[0 +: PINS] = enb_all[rbase +: PINS];
                GRP_TRG, GRP_TRG_M: begin
                    rd_data[0 +: PINS]      = pol_all[rbase +: PINS];
                    rd_data[PINS +: PINS]   = edg_all[rbase +: PINS];
                    rd_data[2*PINS +: PINS] = any_all[rbase +: PINS];
                end
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NBITS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [NBITS-1:0] pin_in,
    input logic             irq,
    input logic [NBITS-1:0] sta,
    input logic [NBITS-1:0] enb,
    input logic [NBITS-1:0] pol,
    input logic [NBITS-1:0] edg
);

    // R3: without a write, no status bit ever falls
    assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(sta) & ~sta) == '0));

    // R8: enable changes only through a write
    assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enb));

    // R2: trigger configuration changes only through a write
    assert_trigger_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pol) && $stable(edg)));

    // R10: with every enable clear the request stays low
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (enb == '0) |-> !irq);

    for (genvar i = 0; i < NBITS; i++) begin : g_lvl
        // R5: an active level latches status on the next edge
        assert_level_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!edg[i] && pol[i] && pin_in[i]) |=> sta[i]);
        assert_level_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!edg[i] && !pol[i] && !pin_in[i]) |=> sta[i]);
    end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NBITS(NBITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .pin_in (pin_in),
    .irq    (irq),
    .sta    (sta_all),
    .enb    (enb_all),
    .pol    (pol_all),
    .edg    (edg_all)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    localparam int NPORTS = 4;
    localparam int NBITS  = NPORTS * 8;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NBITS-1:0] pin_in = '0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [7:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic             irq;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.NPORTS(NPORTS)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] d,
                             input logic ei, input string tag);
        @(negedge clk);
        rd_addr = a;
        q.push_back('{addr: a, data: d, irq: ei, tag: tag});
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input int b, input logic v);
        @(negedge clk);
        pin_in[b] = v;
    endtask

    task automatic pin_and_wr(input int b, input logic v,
                              input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        pin_in[b] = v;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: compare every pending expectation shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (rd_data !== e.data || irq !== e.irq) begin
                    n_err++;
                    $display("FAIL %s addr=%h: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                             e.tag, e.addr, rd_data, irq, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h40, 32'h0, 1'b0, "R1 status reset");
        expect_rd(8'h50, 32'h0, 1'b0, "R1 enable reset");
        expect_rd(8'h60, 32'h0000FFFF, 1'b0, "R1 trigger reset");
        expect_rd(8'h4C, 32'h0, 1'b0, "R1 port3 status reset");

        // R3 rising edge with enable off (R9), then enable (R10), then clear (R6)
        set_pin(0, 1'b1);
        expect_rd(8'h40, 32'h01, 1'b0, "R9 R3 rising latches while disabled");
        reg_wr(8'h50, 32'h01);
        expect_rd(8'h50, 32'h01, 1'b1, "R10 enable raises irq");
        reg_wr(8'h70, 32'h01);
        expect_rd(8'h40, 32'h0, 1'b0, "R6 clear drops status");

        // R8 masked trigger write: pin1 falling
        reg_wr(8'hE0, 32'h0200_0200);
        expect_rd(8'h60, 32'h0000FFFD, 1'b0, "R8 masked trigger pin1");
        set_pin(1, 1'b1);
        expect_rd(8'h40, 32'h0, 1'b0, "R3 falling ignores rise");
        set_pin(1, 1'b0);
        expect_rd(8'h40, 32'h02, 1'b0, "R3 falling latches");
        reg_wr(8'h70, 32'h02);

        // R4 both edges on pin2
        reg_wr(8'hE0, (32'h1 << 26) | (32'h1 << 18) | (32'h1 << 10));
        expect_rd(8'h60, 32'h0004FFF9, 1'b0, "R2 trigger word layout");
        expect_rd(8'hE0, 32'h0004FFF9, 1'b0, "R8 masked trigger alias read");
        set_pin(2, 1'b1);
        expect_rd(8'h40, 32'h04, 1'b0, "R4 both edges rise");
        reg_wr(8'h70, 32'h04);
        expect_rd(8'h40, 32'h0, 1'b0, "R6 clear pin2");
        set_pin(2, 1'b0);
        expect_rd(8'h40, 32'h04, 1'b0, "R4 both edges fall");
        reg_wr(8'h70, 32'h04);

        // R7 detection and clear in the same cycle
        pin_and_wr(3, 1'b1, 8'h70, 32'h08);
        expect_rd(8'h40, 32'h08, 1'b0, "R7 detection beats clear");
        reg_wr(8'h70, 32'h08);
        expect_rd(8'h40, 32'h0, 1'b0, "R6 clear pin3");

        // R8 masked status, R6 status write and zero clear
        reg_wr(8'hC0, 32'h2020);
        expect_rd(8'h40, 32'h20, 1'b0, "R8 masked status set");
        expect_rd(8'hC0, 32'h20, 1'b0, "R8 masked status alias read");
        reg_wr(8'h70, 32'h00);
        expect_rd(8'h40, 32'h20, 1'b0, "R6 zero clear no effect");
        reg_wr(8'h40, 32'hFF);
        expect_rd(8'h40, 32'h0, 1'b0, "R6 status write clears");

        // R8 masked enable
        reg_wr(8'hD0, 32'h0C0C);
        expect_rd(8'h50, 32'h0D, 1'b0, "R8 masked enable set");
        reg_wr(8'hD0, 32'h0100);
        expect_rd(8'hD0, 32'h0C, 1'b0, "R8 masked enable clear");

        // R5 level high on port1
        reg_wr(8'h64, 32'h000000FF);
        expect_rd(8'h44, 32'h0, 1'b0, "R5 level high inactive");
        set_pin(8, 1'b1);
        expect_rd(8'h44, 32'h01, 1'b0, "R5 level high latches");
        reg_wr(8'h74, 32'h01);
        expect_rd(8'h44, 32'h01, 1'b0, "R5 level reappears after clear");
        reg_wr(8'h64, 32'h0);
        expect_rd(8'h44, 32'hFF, 1'b0, "R5 level low latches");
        reg_wr(8'h74, 32'hFF);
        expect_rd(8'h44, 32'hFE, 1'b0, "R5 R9 low level persists disabled");

        // R10 bank-wide OR
        reg_wr(8'h54, 32'h02);
        expect_rd(8'h54, 32'h02, 1'b1, "R10 port1 raises irq");
        reg_wr(8'h54, 32'h00);
        expect_rd(8'h54, 32'h00, 1'b0, "R10 port1 disable drops irq");
        reg_wr(8'h5C, 32'h80);
        expect_rd(8'h5C, 32'h80, 1'b0, "R10 port3 enable no status");
        set_pin(31, 1'b1);
        expect_rd(8'h4C, 32'h80, 1'b1, "R10 port3 edge raises irq");
        reg_wr(8'h7C, 32'h00);
        expect_rd(8'h4C, 32'h80, 1'b1, "R6 zero clear port3");
        reg_wr(8'h4C, 32'hFF);
        expect_rd(8'h4C, 32'h0, 1'b0, "R6 port3 status write clears");

        // R2 unaligned write is ignored
        reg_wr(8'h5D, 32'hFF);
        expect_rd(8'h5C, 32'h80, 1'b0, "R2 unaligned write ignored");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule